// File: doc/BRIEF.md
# Two-Channel Autosweep Sequencer

This block chooses which of two analog inputs drives the sampler of a serial converter whose host interface has only one shared chip-select/frame-sync line. Nothing in the data stream carries a channel number. The host steers the block only through how long it holds that line active.

A complete select window alternates the channel. A complete window means the sampling clocks were delivered, the conversion finished, and only then did the line return high. A window deliberately cut short after four to seven serial clocks forces the selection back to channel 0, so the host can get back in step. Any other window length leaves the selection where it was. A second output tags the channel of the result being shifted out in the current frame.

The block runs in the system clock domain. Its inputs are the already synchronised select level (active low), a one-cycle strobe per serial-clock falling edge, and a conversion-done flag. The control state machine has four states:

- `ST_IDLE`: the line is high.
- `ST_COUNT`: the window is open and clocks are being counted.
- `ST_CONVERT`: sixteen clocks have been seen and the block waits for conversion.
- `ST_DONE`: the conversion has finished.

Its transitions are:

- `open`: IDLE→COUNT on a falling edge of the line.
- `frame_full`: COUNT→CONVERT on the sixteenth strobe.
- `conv_finish`: CONVERT→DONE on the done flag.
- `close`: any active state→IDLE on a rising edge of the line.

Top module: `autosweep_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `chan_sel` is 0 and `result_chan` is 0.
- R2: `chan_sel` changes only in the cycle that follows a detected rising edge of `cs_fs_n`.
- R3: A window that closes after 4, 5, 6 or 7 counted strobes sets `chan_sel` to 0.
- R4: A window that counts 16 strobes and then sees `conv_done` before closing advances `chan_sel` to the other channel (0→1, 1→0).
- R5: A window that closes with fewer than 4 strobes, or with 8 to 15 strobes, leaves `chan_sel` unchanged. So does a window with 16 strobes whose `conv_done` never came, or came only in the closing cycle.
- R6: When a window advances the channel, `result_chan` takes the value `chan_sel` had during that window. Otherwise `result_chan` holds its value.
- R7: The strobe count restarts at each falling edge of `cs_fs_n`, so strobes never carry from one window into the next.
- R8: Strobes while `cs_fs_n` is high are not counted. Strobes past the sixteenth do not stop a window from completing.
- R9: `conv_done` seen before the sixteenth strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_fs_n | input | 1 | Synchronised shared select/frame-sync level, low = window active |
| sclk_fall | input | 1 | One-cycle strobe per serial-clock falling edge |
| conv_done | input | 1 | Conversion-finished flag from the converter core |
| chan_sel | output | 1 | Channel currently routed to the sampler |
| result_chan | output | 1 | Channel of the result shifted out in the current frame |

## Verification
On every cycle the checker keeps its own count of strobes per window and its own record of whether the conversion finished. From these it checks the three outcomes at each closing edge: reset to 0, advance, or hold. It also checks that the channel never moves at any other time and that the result tag moves only together with an advance. The bench scenarios are needed to show the reset value, the effect of strobes arriving outside a window, early done flags, a done flag landing exactly on the closing edge, and saturation past sixteen clocks. These are visible only as sequences of whole windows.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } swp_state_e;

endpackage

// File: rtl/swp_edge_det.sv
module swp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_n,
    output logic open_o,
    output logic close_o
);
    // Idle level is high; reset to it so no false edge after reset.
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_n;
    end

    assign open_o  = level_q & ~level_n;
    assign close_o = ~level_q & level_n;
endmodule

// File: rtl/swp_window_ctr.sv
module swp_window_ctr #(
    parameter int FRAME_CLKS = 16,
    parameter int SHORT_MIN  = 4,
    parameter int SHORT_MAX  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last_o,
    output logic short_o
);
    localparam int CNT_W = $clog2(FRAME_CLKS + 1);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(FRAME_CLKS);
    localparam logic [CNT_W-1:0] PRE_V  = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] LO_V   = CNT_W'(SHORT_MIN);
    localparam logic [CNT_W-1:0] HI_V   = CNT_W'(SHORT_MAX);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clear)                    cnt_q <= '0;
        else if (inc && (cnt_q != FULL_V)) cnt_q <= cnt_q + 1'b1;
    end

    assign last_o  = inc && (cnt_q == PRE_V);
    assign short_o = (cnt_q >= LO_V) && (cnt_q <= HI_V);
endmodule

// File: rtl/swp_chan_reg.sv
module swp_chan_reg #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            to_zero,
    output logic [CH_W-1:0] chan_o,
    output logic [CH_W-1:0] tag_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] chan_q;
    logic [CH_W-1:0] tag_q;
    logic [CH_W-1:0] chan_next;

    always_comb begin
        if (chan_q == LAST_CH) chan_next = '0;
        else                   chan_next = chan_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            tag_q  <= '0;
        end else if (advance) begin
            tag_q  <= chan_q;
            chan_q <= chan_next;
        end else if (to_zero) begin
            chan_q <= '0;
        end
    end

    assign chan_o = chan_q;
    assign tag_o  = tag_q;
endmodule

// File: rtl/autosweep_seq.sv
module autosweep_seq #(
    parameter int NUM_CH     = 2,
    parameter int FRAME_CLKS = 16,
    parameter int SHORT_MIN  = 4,
    parameter int SHORT_MAX  = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cs_fs_n,
    input  logic                                 sclk_fall,
    input  logic                                 conv_done,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] chan_sel,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] result_chan
);
    import swp_pkg::*;

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    swp_state_e state_q, state_d;
    logic win_open, win_close;
    logic cnt_inc, cnt_last, cnt_short;
    logic do_advance, do_zero;

    swp_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_n (cs_fs_n),
        .open_o  (win_open),
        .close_o (win_close)
    );

    swp_window_ctr #(
        .FRAME_CLKS (FRAME_CLKS),
        .SHORT_MIN  (SHORT_MIN),
        .SHORT_MAX  (SHORT_MAX)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_open),
        .inc     (cnt_inc),
        .last_o  (cnt_last),
        .short_o (cnt_short)
    );

    swp_chan_reg #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (do_advance),
        .to_zero (do_zero),
        .chan_o  (chan_sel),
        .tag_o   (result_chan)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic; the closing edge wins over every other event
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win_open) state_d = ST_COUNT;
            ST_COUNT:   if (win_close) state_d = ST_IDLE;
                        else if (cnt_last) state_d = ST_CONVERT;
            ST_CONVERT: if (win_close) state_d = ST_IDLE;
                        else if (conv_done) state_d = ST_DONE;
            ST_DONE:    if (win_close) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        cnt_inc    = 1'b0;
        do_advance = 1'b0;
        do_zero    = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COUNT: begin
                cnt_inc = sclk_fall && !cs_fs_n;
                do_zero = win_close && cnt_short;
            end
            ST_CONVERT: ;
            ST_DONE:    do_advance = win_close;
            default:    ;
        endcase
    end
endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
    parameter int NUM_CH     = 2,
    parameter int FRAME_CLKS = 16,
    parameter int SHORT_MIN  = 4,
    parameter int SHORT_MAX  = 7,
    parameter int CH_W       = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_fs_n,
    input logic            sclk_fall,
    input logic            conv_done,
    input logic [CH_W-1:0] chan_sel,
    input logic [CH_W-1:0] result_chan
);
    localparam int MW = $clog2(FRAME_CLKS + 1);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic          m_prev, m_in, m_done;
    logic [MW-1:0] m_cnt;
    logic          m_fall, m_rise, m_short;

    assign m_fall  = m_prev & ~cs_fs_n;
    assign m_rise  = ~m_prev & cs_fs_n;
    assign m_short = (m_cnt >= MW'(SHORT_MIN)) && (m_cnt <= MW'(SHORT_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev <= 1'b1;
            m_in   <= 1'b0;
            m_done <= 1'b0;
            m_cnt  <= '0;
        end else begin
            m_prev <= cs_fs_n;
            if (m_fall) begin
                m_in   <= 1'b1;
                m_cnt  <= '0;
                m_done <= 1'b0;
            end else if (m_rise) begin
                m_in <= 1'b0;
            end else if (m_in && !cs_fs_n) begin
                if (sclk_fall && (m_cnt != MW'(FRAME_CLKS))) m_cnt <= m_cnt + 1'b1;
                if (conv_done && (m_cnt == MW'(FRAME_CLKS))) m_done <= 1'b1;
            end
        end
    end

    a_r2_move_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !m_rise |=> $stable(chan_sel));

    a_r3_short_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rise && m_short) |=> (chan_sel == '0));

    a_r4_full_window_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rise && m_done) |=>
        (chan_sel == (($past(chan_sel) == LAST_CH) ? '0 : $past(chan_sel) + 1'b1)));

    a_r5_other_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rise && !m_done && !m_short) |=> $stable(chan_sel));

    a_r6_tag_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rise && m_done) |=> (result_chan == $past(chan_sel)));

    a_r6_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rise && m_done) |=> $stable(result_chan));
endmodule

bind autosweep_seq swp_chk #(
    .NUM_CH     (NUM_CH),
    .FRAME_CLKS (FRAME_CLKS),
    .SHORT_MIN  (SHORT_MIN),
    .SHORT_MAX  (SHORT_MAX),
    .CH_W       (CH_W)
) u_chk (.*);

// File: tb/tb_autosweep_seq.sv
module tb_autosweep_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_fs_n = 1'b1;
    logic sclk_fall = 1'b0;
    logic conv_done = 1'b0;
    logic [0:0] chan_sel, result_chan;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    autosweep_seq dut (
        .clk (clk), .rst_n (rst_n), .cs_fs_n (cs_fs_n),
        .sclk_fall (sclk_fall), .conv_done (conv_done),
        .chan_sel (chan_sel), .result_chan (result_chan)
    );

    // {strobes[5:0], done, exp_chan, exp_tag}
    localparam logic [8:0] VEC [16] = '{
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd16, 1'b1, 1'b0, 1'b1},  // R4 R6
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd5,  1'b0, 1'b0, 1'b0},  // R3
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd3,  1'b0, 1'b1, 1'b0},  // R5 below 4
        {6'd10, 1'b0, 1'b1, 1'b0},  // R5 middle range
        {6'd16, 1'b0, 1'b1, 1'b0},  // R5 no done
        {6'd4,  1'b0, 1'b0, 1'b0},  // R3 lower bound
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd7,  1'b0, 1'b0, 1'b0},  // R3 upper bound
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd16, 1'b1, 1'b0, 1'b1},  // R4 R6
        {6'd16, 1'b1, 1'b1, 1'b0},  // R4
        {6'd8,  1'b0, 1'b1, 1'b0},  // R5 just above short range
        {6'd20, 1'b1, 1'b0, 1'b1}   // R8 saturation
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic strobe();
        sclk_fall = 1'b1;
        @(negedge clk);
        sclk_fall = 1'b0;
        @(negedge clk);
    endtask

    // done_mode: 0 none, 1 after the clocks, 2 on the closing edge
    task automatic window(input int n, input int done_mode, input int early_done_at);
        @(negedge clk);
        cs_fs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i == early_done_at) begin
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
            strobe();
        end
        if (done_mode == 1) begin
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            @(negedge clk);
        end
        cs_fs_n = 1'b1;
        if (done_mode == 2) conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 chan in reset", chan_sel, 1'b0);
        check("R1 tag in reset", result_chan, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 chan after reset", chan_sel, 1'b0);
        check("R1 tag after reset", result_chan, 1'b0);

        for (int v = 0; v < 16; v++) begin
            window(int'(VEC[v][8:3]), VEC[v][2] ? 1 : 0, -1);
            check($sformatf("vector %0d chan (R3/R4/R5/R8)", v), chan_sel, VEC[v][1]);
            check($sformatf("vector %0d tag (R6)", v), result_chan, VEC[v][0]);
        end
        // chan_sel is 0, tag 1 here; bring chan_sel to 1
        window(16, 1, -1);
        check("R4 setup", chan_sel, 1'b1);
        check("R6 setup tag", result_chan, 1'b0);

        // R7: two windows of 3 must not sum to a reset
        window(3, 0, -1);
        window(3, 0, -1);
        check("R7 count clears per window", chan_sel, 1'b1);

        // R8: strobes while line is high are not counted
        repeat (3) strobe();
        window(2, 0, -1);
        check("R8 idle strobes ignored", chan_sel, 1'b1);

        // R9: done before sixteenth clock is ignored
        window(16, 0, 9);
        check("R9 early done ignored", chan_sel, 1'b1);
        check("R9 tag unchanged", result_chan, 1'b0);

        // R5: done on the closing edge aborts the advance
        window(16, 2, -1);
        check("R5 done at close", chan_sel, 1'b1);

        // R2: no change while the window stays open after done
        @(negedge clk);
        cs_fs_n = 1'b0;
        repeat (2) @(negedge clk);
        repeat (16) strobe();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 held before rise", chan_sel, 1'b1);
        cs_fs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 moved after rise", chan_sel, 1'b0);
        check("R6 tag after rise", result_chan, 1'b1);

        // R1: reset mid-operation
        window(16, 1, -1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 chan on reset", chan_sel, 1'b0);
        check("R1 tag on reset", result_chan, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule